// File: doc/BRIEF.md
# Single-Wire Byte Link Master

This block is the master-side framing engine for a single-wire bus on which clock and data share one line through Manchester coding. A bit lasts two half periods and always changes level at its midpoint. A rising midpoint edge carries a 1 and a falling one carries a 0. The engine takes one request at a time. A request either wakes and addresses the slave, sends one byte, or reads one byte. Every byte is followed by a two-bit acknowledge slot. In the first bit the master states whether the operation continues. In the second bit the master releases the line and the slave must answer with a 1 bit.

The wake request can open with a long high standby pulse, which is needed after power-up and after any failure. It then holds the line low briefly and sends the synchronisation byte 0x55. The slave never acknowledges that byte, so the engine ignores its acknowledge slot. The device address byte follows at once. A missing or malformed slave acknowledge is reported with the completion pulse and raises a flag asking for a standby pulse before the next command. The line is modelled as a drive value, a drive enable and the resolved input level.

Top module: `swb_byte_master`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0, `need_stby` is 1, and the line is driven high (`line_oe`=1, `line_o`=1).
- R2: Every bit occupies 2*HALF_CYC clock cycles. The master encodes a 1 as low in the first half and high in the second, and a 0 as high then low. Bytes go most significant bit first.
- R3: `req_op`=0 drives the line high for STBY_CYC cycles, then low for LOW_CYC cycles. It then sends 0x55, acknowledge bit 1 and a released slot, followed by DEV_ADDR, acknowledge bit 1 and a checked released slot.
- R4: `req_op`=1 runs the same sequence as R3 without the high standby phase. The low phase starts in the first cycle after acceptance.
- R5: `req_op`=2 sends `req_byte`. The master then drives the acknowledge bit equal to the inverse of `req_last` and releases the line (`line_oe`=0) for the slave slot.
- R6: `req_op`=3 releases the line for 8 bit periods and assembles `rx_byte` MSB first from the direction of each midpoint edge. Acknowledge and slave slot then follow as in R5.
- R7: A checked slave slot passes only if the line shows a rising midpoint edge. No edge, or a falling edge, sets `ack_err` to 1 with `done`.
- R8: Line activity in the slot that follows the 0x55 byte never sets `ack_err`.
- R9: `need_stby` is set by every acknowledge error and is cleared only when a standby high phase completes. An `req_op`=1 sequence leaves it set.
- R10: `done` is a one-cycle pulse. For op 2 or 3 it is visible exactly 10 bit periods after the accepting edge. `rx_byte` changes only when a receive completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_op | input | 2 | 0 standby+wake, 1 wake, 2 send byte, 3 receive byte |
| req_byte | input | 8 | Byte to send for op 2 |
| req_last | input | 1 | Final byte: master acknowledge bit becomes 0 |
| req_ready | output | 1 | Engine idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Last received byte |
| ack_err | output | 1 | Slave acknowledge failure of the last request |
| need_stby | output | 1 | A standby pulse is required before the next command |
| line_i | input | 1 | Resolved level of the bus line |
| line_o | output | 1 | Level driven onto the line |
| line_oe | output | 1 | Master drives the line when 1 |

## Verification
The bench builds the engine with HALF_CYC=8, STBY_CYC=40 and LOW_CYC=12, so one bit spans 16 cycles. With these values a full wake sequence of twenty bits completes within a few hundred cycles. The short timings let the bench sample every half bit of every frame, check the standby and low windows cycle by cycle, and place a scripted slave response in any released slot. That scripted slave covers correct, silent and inverted acknowledges, and it drives an acknowledge into the ignored slot after the synchronisation byte.

// File: rtl/swb_pkg.sv
package swb_pkg;
  typedef enum logic [1:0] {
    OP_STBY_HDR = 2'd0,
    OP_HDR      = 2'd1,
    OP_SEND     = 2'd2,
    OP_RECV     = 2'd3
  } swb_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STBY, ST_LOW, ST_BITS, ST_MAK, ST_SAK
  } swb_state_e;

  typedef enum logic [1:0] {
    STG_HDR, STG_ADDR, STG_USER
  } swb_stage_e;

  localparam logic [7:0] SYNC_BYTE = 8'h55;
endpackage

// File: rtl/swb_sync.sv
module swb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/swb_bitcell.sv
module swb_bitcell #(
  parameter int HALF_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic drive_i,
  input  logic bit_i,
  input  logic line_i,
  output logic active_o,
  output logic last_o,
  output logic line_o,
  output logic line_oe_o,
  output logic rx_bit_o,
  output logic rx_edge_o
);
  localparam int BIT_CYC = 2 * HALF_CYC;
  localparam int CW      = $clog2(BIT_CYC);
  localparam int Q1      = HALF_CYC / 2;
  localparam int Q3      = HALF_CYC + HALF_CYC / 2;

  logic          active_q, active_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          drive_q, drive_d, bit_q, bit_d;
  logic          s1_q, s1_d, s2_q, s2_d;

  assign last_o = active_q && (cnt_q == CW'(BIT_CYC - 1));

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    drive_d  = drive_q;
    bit_d    = bit_q;
    s1_d     = s1_q;
    s2_d     = s2_q;
    if (active_q && cnt_q == CW'(Q1)) s1_d = line_i;
    if (active_q && cnt_q == CW'(Q3)) s2_d = line_i;
    if (start_i) begin
      active_d = 1'b1;
      cnt_d    = '0;
      drive_d  = drive_i;
      bit_d    = bit_i;
    end else if (active_q) begin
      if (last_o) active_d = 1'b0;
      else        cnt_d    = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      drive_q  <= 1'b0;
      bit_q    <= 1'b0;
      s1_q     <= 1'b1;
      s2_q     <= 1'b1;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      drive_q  <= drive_d;
      bit_q    <= bit_d;
      s1_q     <= s1_d;
      s2_q     <= s2_d;
    end
  end

  assign active_o  = active_q;
  assign line_o    = (cnt_q < CW'(HALF_CYC)) ? ~bit_q : bit_q;
  assign line_oe_o = active_q && drive_q;
  assign rx_bit_o  = s2_q;
  assign rx_edge_o = s1_q ^ s2_q;

  // R2
  mid_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && drive_q && cnt_q == CW'(HALF_CYC)) |-> (line_oe_o && (line_o != $past(line_o))));
endmodule

// File: rtl/swb_byte_master.sv
module swb_byte_master
  import swb_pkg::*;
#(
  parameter int         HALF_CYC    = 250,
  parameter int         STBY_CYC    = 60000,
  parameter int         LOW_CYC     = 500,
  parameter logic [7:0] DEV_ADDR    = 8'hA0,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_op,
  input  logic [7:0] req_byte,
  input  logic       req_last,
  output logic       req_ready,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       ack_err,
  output logic       need_stby,
  input  logic       line_i,
  output logic       line_o,
  output logic       line_oe
);
  localparam int TMAX = (STBY_CYC > LOW_CYC) ? STBY_CYC : LOW_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  logic [1:0] rst_pipe_q;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int = rst_pipe_q[1];

  logic line_s;
  swb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int), .d_i(line_i), .q_o(line_s));

  logic cell_start, cell_drive, cell_bit;
  logic cell_active, cell_last, cell_o, cell_oe, rx_bit, rx_edge;

  swb_bitcell #(.HALF_CYC(HALF_CYC)) u_cell (
    .clk(clk), .rst_n(rst_int), .start_i(cell_start), .drive_i(cell_drive),
    .bit_i(cell_bit), .line_i(line_s), .active_o(cell_active), .last_o(cell_last),
    .line_o(cell_o), .line_oe_o(cell_oe), .rx_bit_o(rx_bit), .rx_edge_o(rx_edge));

  swb_state_e    state_q, state_d;
  swb_stage_e    stage_q, stage_d;
  logic          tx_q, tx_d, last_q, last_d;
  logic [7:0]    sh_q, sh_d, rx_q, rx_d;
  logic [2:0]    idx_q, idx_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          done_q, done_d, err_q, err_d, need_q, need_d;
  logic          mak_val, sak_bad;

  assign mak_val = (stage_q == STG_USER) ? ~last_q : 1'b1;
  assign sak_bad = !(rx_edge && rx_bit);

  always_comb begin
    state_d = state_q;  stage_d = stage_q;  tx_d = tx_q;  last_d = last_q;
    sh_d = sh_q;  rx_d = rx_q;  idx_d = idx_q;  tmr_d = tmr_q;
    done_d = 1'b0;  err_d = err_q;  need_d = need_q;
    cell_start = 1'b0;  cell_drive = 1'b1;  cell_bit = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        last_d = req_last;
        stage_d = STG_USER;
        tmr_d = '0;
        idx_d = 3'd7;
        case (swb_op_e'(req_op))
          OP_STBY_HDR: state_d = ST_STBY;
          OP_HDR:      state_d = ST_LOW;
          OP_SEND: begin
            state_d = ST_BITS;  tx_d = 1'b1;  sh_d = req_byte;
            cell_start = 1'b1;  cell_bit = req_byte[7];
          end
          default: begin
            state_d = ST_BITS;  tx_d = 1'b0;
            cell_start = 1'b1;  cell_drive = 1'b0;
          end
        endcase
      end
      ST_STBY: begin
        if (tmr_q == TW'(STBY_CYC - 1)) begin
          state_d = ST_LOW;  tmr_d = '0;  need_d = 1'b0;
        end else tmr_d = tmr_q + 1'b1;
      end
      ST_LOW: begin
        if (tmr_q == TW'(LOW_CYC - 1)) begin
          state_d = ST_BITS;  stage_d = STG_HDR;  tx_d = 1'b1;
          sh_d = SYNC_BYTE;  idx_d = 3'd7;
          cell_start = 1'b1;  cell_bit = SYNC_BYTE[7];
        end else tmr_d = tmr_q + 1'b1;
      end
      ST_BITS: if (cell_last) begin
        if (!tx_q) sh_d = {sh_q[6:0], rx_bit};
        cell_start = 1'b1;
        if (idx_q == 3'd0) begin
          state_d = ST_MAK;  cell_bit = mak_val;
        end else begin
          idx_d = idx_q - 3'd1;
          cell_drive = tx_q;
          cell_bit = sh_q[idx_q - 3'd1];
        end
      end
      ST_MAK: if (cell_last) begin
        state_d = ST_SAK;  cell_start = 1'b1;  cell_drive = 1'b0;
      end
      ST_SAK: if (cell_last) begin
        if (stage_q == STG_HDR) begin
          state_d = ST_BITS;  stage_d = STG_ADDR;  tx_d = 1'b1;
          sh_d = DEV_ADDR;  idx_d = 3'd7;
          cell_start = 1'b1;  cell_bit = DEV_ADDR[7];
        end else begin
          state_d = ST_IDLE;  done_d = 1'b1;  err_d = sak_bad;
          if (sak_bad) need_d = 1'b1;
          if (stage_q == STG_USER && !tx_q) rx_d = sh_q;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      state_q <= ST_IDLE;  stage_q <= STG_USER;  tx_q <= 1'b0;  last_q <= 1'b0;
      sh_q <= '0;  rx_q <= '0;  idx_q <= '0;  tmr_q <= '0;
      done_q <= 1'b0;  err_q <= 1'b0;  need_q <= 1'b1;
    end else begin
      state_q <= state_d;  stage_q <= stage_d;  tx_q <= tx_d;  last_q <= last_d;
      sh_q <= sh_d;  rx_q <= rx_d;  idx_q <= idx_d;  tmr_q <= tmr_d;
      done_q <= done_d;  err_q <= err_d;  need_q <= need_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign done      = done_q;
  assign rx_byte   = rx_q;
  assign ack_err   = err_q;
  assign need_stby = need_q;
  assign line_o    = cell_active ? cell_o  : (state_q != ST_LOW);
  assign line_oe   = cell_active ? cell_oe : 1'b1;

  // R3
  stby_high_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (state_q == ST_STBY) |-> (line_o && line_oe));
  // R6
  rx_release_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (state_q == ST_BITS && !tx_q) |-> !line_oe);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int)
    done |=> !done);
  // R9
  err_needs_stby_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (done && ack_err) |-> need_stby);
endmodule

// File: tb/swb_byte_master_bench.sv
module swb_byte_master_bench;
  localparam int HALF = 8;
  localparam int BIT  = 2 * HALF;
  localparam int STBY = 40;
  localparam int LOW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [7:0] req_byte = 8'h00;
  logic req_last = 1'b0;
  logic req_ready, done, ack_err, need_stby, line_o, line_oe, line_w;
  logic [7:0] rx_byte;
  logic slv_en = 1'b0;
  logic slv_val = 1'b1;
  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  assign line_w = line_oe ? line_o : (slv_en ? slv_val : 1'b1);

  swb_byte_master #(.HALF_CYC(HALF), .STBY_CYC(STBY), .LOW_CYC(LOW), .DEV_ADDR(8'hA0))
  u_swb_byte_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_byte(req_byte), .req_last(req_last), .req_ready(req_ready), .done(done),
    .rx_byte(rx_byte), .ack_err(ack_err), .need_stby(need_stby),
    .line_i(line_w), .line_o(line_o), .line_oe(line_oe));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Decode one bit: 1 rising mid edge, 0 falling, 2 no edge.
  task automatic grab(output int code, output logic oe);
    logic a, b;
    repeat (HALF / 2) @(negedge clk);
    a = line_w;
    oe = line_oe;
    repeat (HALF) @(negedge clk);
    b = line_w;
    repeat (HALF / 2) @(negedge clk);
    code = (!a && b) ? 1 : ((a && !b) ? 0 : 2);
  endtask

  task automatic grab_byte(output logic [7:0] val, output logic oe_any);
    int c;
    logic oe;
    val = 8'h00;
    oe_any = 1'b0;
    for (int i = 0; i < 8; i++) begin
      grab(c, oe);
      val = {val[6:0], (c == 1)};
      if (c == 2) val = 8'hxx;
      oe_any |= oe;
    end
  endtask

  // Slave bit: kind 1 rising, 0 falling, 2 silent.
  task automatic slave_drive(input int kind);
    slv_en = 1'b1;
    slv_val = (kind == 1) ? 1'b0 : 1'b1;
    repeat (HALF) @(negedge clk);
    slv_val = (kind == 0) ? 1'b0 : 1'b1;
    repeat (HALF) @(negedge clk);
    slv_en = 1'b0;
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] data, input logic last);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_byte = data; req_last = last;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ready", req_ready, 1);
    chk("R1 done", done, 0);
    chk("R1 need_stby", need_stby, 1);
    chk("R1 line high", {line_oe, line_o}, 2'b11);
  endtask

  task automatic t_hdr(input bit stby, input int hdr_kind, input int addr_kind,
                       input logic exp_err, input logic exp_need);
    logic [7:0] hb, ab;
    logic oe_x, oe1, oe2;
    int m1, m2, s1, s2, bad;
    issue(stby ? 2'd0 : 2'd1, 8'h00, 1'b0);
    if (stby) begin
      bad = 0;
      repeat (STBY) begin
        if (!(line_w && line_oe)) bad++;
        @(negedge clk);
      end
      chk("R3 standby high window", bad, 0);
    end
    bad = 0;
    repeat (LOW) begin
      if (line_w !== 1'b0 || !line_oe) bad++;
      @(negedge clk);
    end
    chk(stby ? "R3 low window" : "R4 low window immediate", bad, 0);
    fork
      begin
        grab_byte(hb, oe_x); grab(m1, oe_x); grab(s1, oe1);
        grab_byte(ab, oe_x); grab(m2, oe_x); grab(s2, oe2);
      end
      begin
        repeat (9 * BIT) @(negedge clk);
        slave_drive(hdr_kind);
        repeat (9 * BIT) @(negedge clk);
        slave_drive(addr_kind);
      end
    join
    chk("R2 sync byte 55", hb, 8'h55);
    chk("R3 sync ack bit", m1, 1);
    chk("R3 sync slot released", oe1, 0);
    chk("R3 address byte", ab, 8'hA0);
    chk("R3 address ack bit", m2, 1);
    chk("R10 done after wake", done, 1);
    chk("R8 R7 ack_err after wake", ack_err, exp_err);
    chk("R9 need_stby after wake", need_stby, exp_need);
    @(negedge clk);
    chk("R10 done single cycle", done, 0);
  endtask

  task automatic t_send(input logic [7:0] data, input logic last, input int kind,
                        input logic exp_err, input logic [7:0] exp_rx);
    logic [7:0] got;
    logic oe_x, sak_oe;
    int mak, sak;
    issue(2'd2, data, last);
    fork
      begin grab_byte(got, oe_x); grab(mak, oe_x); grab(sak, sak_oe); end
      begin repeat (9 * BIT) @(negedge clk); slave_drive(kind); end
    join
    chk("R5 R2 sent byte", got, data);
    chk("R5 ack bit inverse of last", mak, {31'd0, ~last});
    chk("R5 slave slot released", sak_oe, 0);
    chk("R10 done at 10 bits", done, 1);
    chk("R7 ack_err", ack_err, exp_err);
    chk("R10 rx_byte held", rx_byte, exp_rx);
    if (exp_err) chk("R9 need_stby on error", need_stby, 1);
    @(negedge clk);
    chk("R10 done single cycle", done, 0);
  endtask

  task automatic t_recv(input logic [7:0] data, input logic last, input int kind,
                        input logic exp_err);
    logic [7:0] seen;
    logic oe_any, oe_x;
    int mak, sak;
    issue(2'd3, 8'h00, last);
    fork
      begin grab_byte(seen, oe_any); grab(mak, oe_x); grab(sak, oe_x); end
      begin
        for (int i = 0; i < 8; i++) slave_drive(data[7-i] ? 1 : 0);
        repeat (BIT) @(negedge clk);
        slave_drive(kind);
      end
    join
    chk("R6 line released for data", oe_any, 0);
    chk("R6 ack bit inverse of last", mak, {31'd0, ~last});
    chk("R10 done at 10 bits", done, 1);
    chk("R6 received byte", rx_byte, data);
    chk("R7 ack_err", ack_err, exp_err);
    @(negedge clk);
    chk("R10 done single cycle", done, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_hdr(1'b1, 0, 1, 1'b0, 1'b0);
    t_send(8'hA5, 1'b0, 1, 1'b0, 8'h00);
    t_recv(8'h3C, 1'b0, 1, 1'b0);
    t_recv(8'hC3, 1'b1, 1, 1'b0);
    t_send(8'h0F, 1'b1, 2, 1'b1, 8'hC3);
    t_hdr(1'b0, 1, 1, 1'b0, 1'b1);
    t_send(8'h81, 1'b0, 0, 1'b1, 8'hC3);
    t_hdr(1'b1, 2, 2, 1'b1, 1'b1);
    t_hdr(1'b1, 1, 1, 1'b0, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule